// File: doc/BRIEF.md
# Overlap-Save Segment Sequencer

This block feeds a fast-convolution chain (forward transform, spectral multiply, inverse transform) one fixed-length segment at a time. Complex baseband samples arrive with a valid strobe and are written into a circular buffer. When enough fresh samples are waiting, the sequencer pulses a start toward the chain. The chain then fetches the segment through a read port by giving an offset inside the segment window. Each window ends at the newest consumed sample. Its leading part repeats the tail of the previous window, which gives the overlap that overlap-save filtering discards.

After the start, the sequencer holds in a drain state. It leaves only when the chain has produced a full segment's worth of outputs, counted from the start pulse, and also reports idle. Moving on at the first output strobe would let the next start race a chain that is still emitting, and the handshake would stall after the first segment. Samples that arrive while the chain is busy keep landing in the buffer. The sequencer also reports the segment index within the chirp, both buffer pointers and a running count of chirp samples.

Top module: `ovs_segment_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the sequencer returns to idle. `chain_start` is low, and `seg_index`, `buf_wr_ptr`, `buf_rd_ptr` (with `chain_rd_off` = 0) and `chirp_samples` are all zero.
- R2: Every cycle with `in_valid` high writes `in_sample` at the address shown on `buf_wr_ptr`. The pointer then steps by one modulo the buffer depth of 2*SEG_LEN. This applies in every state, including while the chain is draining.
- R3: At least NEW_LEN fresh samples may be pending after the write edge of a sample while the sequencer is idle. In that case `chain_start` rises one clock later and stays high for exactly one cycle. Those NEW_LEN samples then stop counting as pending.
- R4: `chain_rd_data` returns, one cycle after `chain_rd_off` = p is presented, the sample at window position p. The window is the SEG_LEN samples that end at the newest sample consumed by the latest start. Positions 0 to SEG_LEN-NEW_LEN-1 therefore hold the last samples of the previous window.
- R5: The segment does not advance, and no new start is issued, until SEG_LEN `chain_out_valid` cycles have been counted since the start pulse. This holds even if `chain_idle` is high and some outputs were seen earlier.
- R6: After SEG_LEN outputs, the segment does not advance while `chain_idle` is low.
- R7: Outputs may be complete and `chain_idle` high at a rising edge in the drain state. That edge increments `seg_index`. If NEW_LEN samples are already pending, `chain_start` follows one cycle later.
- R8: After segment SEGS_PER_CHIRP-1 completes, `seg_index` returns to 0.
- R9: `chirp_samples` rises by one per valid sample. It drops by NEW_LEN*SEGS_PER_CHIRP on the edge where the segment index wraps.
- R10: No stored sample needed by the current window is overwritten as long as pending samples never exceed SEG_LEN.
- R11: `buf_rd_ptr` equals the buffer address of window position 0 plus `chain_rd_off`, modulo the buffer depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 2*SAMPLE_W | Complex sample, I in upper half, Q in lower half |
| chain_start | output | 1 | One-cycle start pulse to the chain |
| chain_rd_off | input | log2(SEG_LEN) | Offset inside the segment window requested by the chain |
| chain_rd_data | output | 2*SAMPLE_W | Sample at the requested offset, one cycle later |
| chain_out_valid | input | 1 | Chain output strobe |
| chain_idle | input | 1 | Chain reports idle |
| seg_index | output | log2(SEGS_PER_CHIRP) | Segment number within the chirp |
| buf_wr_ptr | output | log2(SEG_LEN)+1 | Next buffer write address |
| buf_rd_ptr | output | log2(SEG_LEN)+1 | Buffer address currently read |
| chirp_samples | output | log2(NEW_LEN*SEGS_PER_CHIRP+2*SEG_LEN+1) | Samples collected in the current chirp |

## Verification
The bench builds the block with SEG_LEN = 16, NEW_LEN = 12 and SEGS_PER_CHIRP = 3, with 8-bit components, giving a 32-entry buffer and a 4-sample overlap. These values let a few dozen samples cover a wrap of the write pointer, a window that straddles the end of the buffer, an overlap read spanning two segments, and a full chirp ending in a segment-index wrap. The drain gate is probed directly. One early output is followed by an idle chain with a full segment already pending, and then all outputs are given while the chain stays busy.

// File: rtl/ovs_pkg.sv
// Shared types for the overlap-save segment sequencer.
package ovs_pkg;
    // Sequencer control states.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_DRAIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ovs_ring_ram.sv
// Circular sample store: one write port, one registered read port.
// Assumes the caller manages address wrap; contents are not reset.
module ovs_ring_ram #(
    parameter int AW = 11,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    // Store each accepted sample.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/ovs_fill_tracker.sv
// Tracks the write pointer, the consumed boundary and the chirp sample
// count. Pending samples are the distance between write pointer and the
// consumed boundary. Assumes consume is only raised when seg_ready is high.
module ovs_fill_tracker #(
    parameter int SEG_LEN = 1024,
    parameter int NEW_LEN = 896,
    parameter int SEGS    = 8,
    parameter int AW      = 11,
    parameter int CW      = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          consume,
    input  logic          chirp_wrap,
    output logic          seg_ready,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] next_base,
    output logic [CW-1:0] chirp_cnt
);
    localparam int DEPTH     = 1 << AW;
    localparam int CHIRP_NEW = NEW_LEN * SEGS;
    localparam int HEADROOM  = DEPTH - SEG_LEN;

    logic [AW:0]   wr_q;
    logic [AW:0]   end_q;
    logic [AW:0]   pending;
    logic [CW-1:0] cnt_q;

    assign pending   = wr_q - end_q;
    assign seg_ready = pending >= (AW+1)'(NEW_LEN);
    assign wr_addr   = wr_q[AW-1:0];
    assign next_base = end_q[AW-1:0] + AW'(NEW_LEN) - AW'(SEG_LEN);
    assign chirp_cnt = cnt_q;

    // Advance the write pointer per sample and the boundary per launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            end_q <= '0;
        end else begin
            if (in_valid) wr_q  <= wr_q + 1'b1;
            if (consume)  end_q <= end_q + (AW+1)'(NEW_LEN);
        end
    end

    // Count chirp samples, removing one chirp's worth at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CW'(in_valid) - (chirp_wrap ? CW'(CHIRP_NEW) : '0);
    end

    assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_q == $past(wr_q) + 1'b1);

    assert_consume_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> seg_ready);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= (AW+1)'(HEADROOM));
endmodule

// File: rtl/ovs_drain_counter.sv
// Counts chain output strobes since the last start pulse and flags when a
// whole segment has come out. Assumes the chain emits at most SEG_LEN.
module ovs_drain_counter #(
    parameter int SEG_LEN = 1024,
    parameter int DCW     = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic out_valid,
    output logic done
);
    logic [DCW-1:0] cnt_q;

    // Clear on start, otherwise count outputs up to one segment.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt_q <= '0;
        else if (clear)                              cnt_q <= '0;
        else if (out_valid && cnt_q != DCW'(SEG_LEN)) cnt_q <= cnt_q + 1'b1;
    end

    assign done = cnt_q == DCW'(SEG_LEN);

    assert_no_extra_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !clear) |-> !done);
endmodule

// File: rtl/ovs_segment_sequencer.sv
// Overlap-save segment sequencer. Buffers samples in a ring of 2*SEG_LEN,
// launches the chain when NEW_LEN fresh samples are waiting, serves the
// window through an offset read port and waits for a full drain (all
// SEG_LEN outputs plus chain idle) before moving to the next segment.
// Assumes SEG_LEN is a power of two, NEW_LEN <= SEG_LEN, SEGS_PER_CHIRP >= 2.
module ovs_segment_sequencer
    import ovs_pkg::*;
#(
    parameter int SAMPLE_W       = 16,
    parameter int SEG_LEN        = 1024,
    parameter int NEW_LEN        = 896,
    parameter int SEGS_PER_CHIRP = 8
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             in_valid,
    input  logic [2*SAMPLE_W-1:0]                            in_sample,
    output logic                                             chain_start,
    input  logic [$clog2(SEG_LEN)-1:0]                       chain_rd_off,
    output logic [2*SAMPLE_W-1:0]                            chain_rd_data,
    input  logic                                             chain_out_valid,
    input  logic                                             chain_idle,
    output logic [$clog2(SEGS_PER_CHIRP)-1:0]                seg_index,
    output logic [$clog2(SEG_LEN):0]                         buf_wr_ptr,
    output logic [$clog2(SEG_LEN):0]                         buf_rd_ptr,
    output logic [$clog2(NEW_LEN*SEGS_PER_CHIRP+2*SEG_LEN+1)-1:0] chirp_samples
);
    localparam int OW  = $clog2(SEG_LEN);
    localparam int AW  = OW + 1;
    localparam int DW  = 2 * SAMPLE_W;
    localparam int SIW = $clog2(SEGS_PER_CHIRP);
    localparam int CW  = $clog2(NEW_LEN*SEGS_PER_CHIRP + 2*SEG_LEN + 1);
    localparam int DCW = $clog2(SEG_LEN + 1);

    seq_state_e     state_q;
    logic [SIW-1:0] seg_q;
    logic [AW-1:0]  base_q;
    logic [AW-1:0]  next_base;
    logic [AW-1:0]  wr_addr;
    logic           seg_ready;
    logic           drain_done;
    logic           leave_drain;
    logic           chirp_wrap;

    assign chain_start = state_q == SQ_LAUNCH;
    assign leave_drain = (state_q == SQ_DRAIN) && drain_done && chain_idle;
    assign chirp_wrap  = leave_drain && (seg_q == SIW'(SEGS_PER_CHIRP - 1));
    assign buf_rd_ptr  = base_q + AW'(chain_rd_off);
    assign buf_wr_ptr  = wr_addr;
    assign seg_index   = seg_q;

    ovs_fill_tracker #(
        .SEG_LEN (SEG_LEN),
        .NEW_LEN (NEW_LEN),
        .SEGS    (SEGS_PER_CHIRP),
        .AW      (AW),
        .CW      (CW)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .consume    (chain_start),
        .chirp_wrap (chirp_wrap),
        .seg_ready  (seg_ready),
        .wr_addr    (wr_addr),
        .next_base  (next_base),
        .chirp_cnt  (chirp_samples)
    );

    ovs_ring_ram #(
        .AW (AW),
        .DW (DW)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_addr (wr_addr),
        .wr_data (in_sample),
        .rd_addr (buf_rd_ptr),
        .rd_data (chain_rd_data)
    );

    ovs_drain_counter #(
        .SEG_LEN (SEG_LEN),
        .DCW     (DCW)
    ) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (chain_start),
        .out_valid (chain_out_valid),
        .done      (drain_done)
    );

    // Control state: collect, launch for one cycle, hold until full drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE:   if (seg_ready)   state_q <= SQ_LAUNCH;
                SQ_LAUNCH:                  state_q <= SQ_DRAIN;
                SQ_DRAIN:  if (leave_drain) state_q <= SQ_IDLE;
                default:                    state_q <= SQ_IDLE;
            endcase
        end
    end

    // Segment index: advance on full drain, back to zero at chirp end.
    always_ff @(posedge clk) begin
        if (!rst_n)           seg_q <= '0;
        else if (chirp_wrap)  seg_q <= '0;
        else if (leave_drain) seg_q <= seg_q + 1'b1;
    end

    // Window base: captured at launch from the boundary before it moves.
    always_ff @(posedge clk) begin
        if (!rst_n)           base_q <= '0;
        else if (chain_start) base_q <= next_base;
    end

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chain_start |=> !chain_start);

    assert_gated_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q != $past(seg_q)) |-> $past(drain_done && chain_idle));

    assert_no_start_in_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_DRAIN && !chain_idle) |=> !chain_start);

    assert_index_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_wrap |=> seg_q == '0);
endmodule

// File: tb/sim_ovs_segment_sequencer.sv
`timescale 1ns / 1ps
module sim_ovs_segment_sequencer;
    localparam int SW   = 8;
    localparam int SEG  = 16;
    localparam int NEWL = 12;
    localparam int SEGS = 3;
    localparam int DEP  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        chain_start;
    logic [3:0]  chain_rd_off = '0;
    logic [15:0] chain_rd_data;
    logic        chain_out_valid = 1'b0;
    logic        chain_idle = 1'b1;
    logic [1:0]  seg_index;
    logic [4:0]  buf_wr_ptr;
    logic [4:0]  buf_rd_ptr;
    logic [$clog2(NEWL*SEGS+2*SEG+1)-1:0] chirp_samples;

    int checks = 0;
    int failures = 0;
    int next_n = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ovs_segment_sequencer #(
        .SAMPLE_W(SW), .SEG_LEN(SEG), .NEW_LEN(NEWL), .SEGS_PER_CHIRP(SEGS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .chain_start(chain_start), .chain_rd_off(chain_rd_off),
        .chain_rd_data(chain_rd_data), .chain_out_valid(chain_out_valid),
        .chain_idle(chain_idle), .seg_index(seg_index), .buf_wr_ptr(buf_wr_ptr),
        .buf_rd_ptr(buf_rd_ptr), .chirp_samples(chirp_samples)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Feed n consecutive numbered samples, one per cycle.
    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid  = 1'b1;
            in_sample = 16'(next_n);
            next_n++;
            step();
        end
        in_valid = 1'b0;
    endtask

    // Read window positions from first_p upward; window starts at sample base.
    task automatic read_window(input int base, input int first_p, input string tag);
        for (int p = first_p; p < SEG; p++) begin
            chain_rd_off = 4'(p);
            #1;
            chk(int'(buf_rd_ptr) == ((base + p + DEP) % DEP), {tag, " R11 rd_ptr"},
                int'(buf_rd_ptr), (base + p + DEP) % DEP);
            step();
            chk(int'(chain_rd_data) == base + p, {tag, " R4 rd_data"},
                int'(chain_rd_data), base + p);
        end
        chain_rd_off = '0;
    endtask

    task automatic emit_outputs(input int n);
        for (int i = 0; i < n; i++) begin
            chain_out_valid = 1'b1;
            step();
        end
        chain_out_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) step();
        chk(chain_start == 1'b0, "R1 start", int'(chain_start), 0);
        chk(seg_index == 0, "R1 seg", int'(seg_index), 0);
        chk(buf_wr_ptr == 0, "R1 wr_ptr", int'(buf_wr_ptr), 0);
        chk(buf_rd_ptr == 0, "R1 rd_ptr", int'(buf_rd_ptr), 0);
        chk(chirp_samples == 0, "R1 chirp", int'(chirp_samples), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_launch();
        feed(NEWL - 1);
        chk(chain_start == 1'b0, "R3 no start early", int'(chain_start), 0);
        chk(buf_wr_ptr == 11, "R2 wr_ptr", int'(buf_wr_ptr), 11);
        chk(chirp_samples == 11, "R9 count", int'(chirp_samples), 11);
        feed(1);
        chk(chain_start == 1'b0, "R3 start latency", int'(chain_start), 0);
        step();
        chk(chain_start == 1'b1, "R3 start", int'(chain_start), 1);
        chain_idle = 1'b0;
        step();
        chk(chain_start == 1'b0, "R3 single cycle", int'(chain_start), 0);
        read_window(NEWL - SEG, SEG - NEWL, "seg0");
    endtask

    task automatic t_early_idle();
        bit bad = 0;
        emit_outputs(1);
        chain_idle = 1'b1;
        for (int i = 0; i < NEWL; i++) begin
            in_valid  = 1'b1;
            in_sample = 16'(next_n);
            next_n++;
            step();
            if (seg_index != 0 || chain_start) bad = 1;
        end
        in_valid = 1'b0;
        repeat (3) begin
            step();
            if (seg_index != 0 || chain_start) bad = 1;
        end
        chk(!bad, "R5 no advance before all outputs", int'(bad), 0);
        chk(buf_wr_ptr == 24, "R2 wr_ptr during drain", int'(buf_wr_ptr), 24);
        chk(chirp_samples == 24, "R9 count", int'(chirp_samples), 24);
    endtask

    task automatic t_busy_hold();
        bit bad = 0;
        chain_idle = 1'b0;
        emit_outputs(SEG - 1);
        repeat (3) begin
            step();
            if (seg_index != 0 || chain_start) bad = 1;
        end
        chk(!bad, "R6 no advance while busy", int'(bad), 0);
    endtask

    task automatic t_release();
        chain_idle = 1'b1;
        step();
        chk(seg_index == 1, "R7 seg advance", int'(seg_index), 1);
        chk(chain_start == 1'b0, "R7 start latency", int'(chain_start), 0);
        step();
        chk(chain_start == 1'b1, "R7 restart", int'(chain_start), 1);
        chain_idle = 1'b0;
        step();
        read_window(2*NEWL - SEG, 0, "seg1 overlap");
    endtask

    task automatic t_pointer_wrap();
        emit_outputs(SEG);
        chain_idle = 1'b1;
        step();
        chk(seg_index == 2, "R7 seg advance", int'(seg_index), 2);
        feed(NEWL);
        chk(buf_wr_ptr == 4, "R2 wr_ptr wrap", int'(buf_wr_ptr), 4);
        step();
        chk(chain_start == 1'b1, "R3 start", int'(chain_start), 1);
        chain_idle = 1'b0;
        step();
        read_window(3*NEWL - SEG, 0, "seg2 wrap");
    endtask

    task automatic t_chirp_wrap();
        feed(2);
        chk(chirp_samples == 38, "R9 count", int'(chirp_samples), 38);
        emit_outputs(SEG);
        chk(seg_index == 2, "R6 hold busy", int'(seg_index), 2);
        chain_idle = 1'b1;
        step();
        chk(seg_index == 0, "R8 index wrap", int'(seg_index), 0);
        chk(chirp_samples == 2, "R9 chirp wrap", int'(chirp_samples), 2);
        chk(chain_start == 1'b0, "R3 not ready", int'(chain_start), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_launch();
        t_early_idle();
        t_busy_hold();
        t_release();
        t_pointer_wrap();
        t_chirp_wrap();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule